// File: doc/BRIEF.md
# Two-Wire Single-Byte Register Slave

This block is a slave-only endpoint for an I2C-compatible two-wire bus. It gives a host read and write access to a small bank of byte-wide registers. Both bus lines are brought into the system clock domain through a synchroniser. Edge detectors then find clock edges, start conditions and stop conditions. A state machine decodes the device address and the direction bit. It then takes one register-address byte and exactly one data byte per transaction. There is no address auto-increment, so a value held across two registers takes two separate transactions. The block pulls the data line low only to acknowledge and to send read data.

A write is: start, device address with the direction bit low, register address, data, stop. A read first sets the register pointer with a write that carries no data byte. It is followed by a repeated start, the device address with the direction bit high, and one data byte sent by the slave. The pointer is kept across starts and stops, so a read may also open a new transaction after a stop. Every completed register write gives a one-cycle strobe with its address and data. A stop that closes such a write gives a one-cycle pulse.

The state machine has eleven states. ST_IDLE waits for a start. ST_DEVADDR shifts in the address byte and moves to ST_DEVACK on a match or to ST_IGNORE on a mismatch. ST_DEVACK goes to ST_REGADDR for a write or to ST_RDATA for a read. ST_REGADDR leads to ST_REGACK, then to ST_WDATA, then to ST_WDACK, then to ST_DONE. ST_RDATA leads to ST_RDACK, then to ST_DONE. ST_DONE and ST_IGNORE keep the data line released. A stop sends any state to ST_IDLE. A start, first or repeated, sends any state to ST_DEVADDR.

Top module: `twowire_regbank_slave`

## Requirements
- R1: After reset, every register reads 0x00, the data-line pull-down (`sda_oe`) is inactive, and `wr_stb` and `wr_stop` are low.
- R2: A start is the data line falling while the clock line is high, and a stop is the data line rising while the clock line is high. A stop returns the block to idle with the data line released. The register pointer set by one transaction is used by a read that begins after a later stop and start.
- R3: The device address is 7'b0001000, sent MSB first and followed by a direction bit (0 = write, 1 = read). Any other address gets no acknowledge. The data line then stays released until the next start or stop, and no register changes.
- R4: In a write, the slave acknowledges the address byte, the register-address byte and the data byte by holding the data line low through the ninth clock high period. When the data byte ends, `wr_stb` is high for one cycle with `wr_addr` and `wr_data` equal to the register and the data, and the register takes the new value.
- R5: Only one data byte is accepted per transaction. A further byte before the stop gets no acknowledge and is not written.
- R6: In a read, the slave sends the addressed register MSB first. It changes the data line only while the clock line is low.
- R7: A register address of 0x10 or above is acknowledged in a write, but the data is discarded and no `wr_stb` is given. A read from such an address returns 0x00.
- R8: `wr_stop` pulses for one cycle on a stop that closes a transaction with a completed in-range register write. It does not pulse after reads or after transactions that only set the pointer.
- R9: A repeated start at any point, including in the middle of a byte or while ignoring a mismatched address, restarts address decoding.
- R10: Registers that a write does not address keep their values, and the whole bank is visible on `reg_bank`, with register n at bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_stb | output | 1 | One-cycle strobe for a completed register write |
| wr_addr | output | 4 | Register index of the write |
| wr_data | output | 8 | Data byte of the write |
| wr_stop | output | 1 | One-cycle pulse on a stop that closes a completed write |
| reg_bank | output | 128 | All registers, register n at bits [8n+7:8n] |

## Verification
The bench sends all 128 device addresses with both directions. A decoder that compares too few bits would then acknowledge a foreign address or write a register. It writes and reads back every register with distinct values, which catches a swapped bit order or a wrong shift count. It also sends a second data byte, which a design without a byte limit would acknowledge and store. It issues repeated starts in the middle of a register-address byte and while ignoring a foreign address. A design that did not restart decoding would lose the next write. Out-of-range addresses, pointer-only transactions and reads check that neither the write strobe nor the stop pulse fires when no in-range write completed. A monitor counts any change of the slave's drive while the clock is high.

// File: rtl/twr_pkg.sv
package twr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVADDR,
        ST_DEVACK,
        ST_REGADDR,
        ST_REGACK,
        ST_WDATA,
        ST_WDACK,
        ST_RDATA,
        ST_RDACK,
        ST_DONE,
        ST_IGNORE
    } twr_state_e;

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic ev_rise,
    output logic ev_fall,
    output logic ev_start,
    output logic ev_stop
);

    logic [SYNC_STAGES-1:0] scl_ff;
    logic [SYNC_STAGES-1:0] sda_ff;
    logic                   scl_d;
    logic                   sda_d;

    // Idle bus is high on both lines, so every flop resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_raw};
            sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_raw};
            scl_d  <= scl_ff[SYNC_STAGES-1];
            sda_d  <= sda_ff[SYNC_STAGES-1];
        end
    end

    assign scl_s    = scl_ff[SYNC_STAGES-1];
    assign sda_s    = sda_ff[SYNC_STAGES-1];
    assign ev_rise  = scl_s & ~scl_d;
    assign ev_fall  = ~scl_s & scl_d;
    // Conditions only count while the clock stayed high over both samples
    assign ev_start = scl_s & scl_d & sda_d & ~sda_s;
    assign ev_stop  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/twr_regfile.sv
module twr_regfile #(
    parameter int NUM_REGS = 16,
    parameter int DATA_W   = 8,
    localparam int ADDR_W  = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [ADDR_W-1:0]          waddr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [ADDR_W-1:0]          raddr,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_REGS*DATA_W-1:0] bank
);

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (we && (waddr == ADDR_W'(g))) begin
                regs[g] <= wdata;
            end
        end
        assign bank[g*DATA_W +: DATA_W] = regs[g];
    end

    assign rdata = regs[raddr];

endmodule

// File: rtl/twowire_regbank_slave.sv
module twowire_regbank_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'b0001000,
    parameter int         NUM_REGS    = 16,
    parameter int         SYNC_STAGES = 2,
    localparam int        ADDR_W      = $clog2(NUM_REGS),
    localparam int        BW          = twr_pkg::BYTE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    output logic                   wr_stb,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [BW-1:0]          wr_data,
    output logic                   wr_stop,
    output logic [NUM_REGS*BW-1:0] reg_bank
);
    import twr_pkg::*;

    localparam logic [3:0] BITS_FULL = 4'(BW);

    logic scl_s, sda_s, ev_rise, ev_fall, ev_start, ev_stop;

    twr_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_raw  (scl_i),
        .sda_raw  (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall),
        .ev_start (ev_start),
        .ev_stop  (ev_stop)
    );

    twr_state_e    state_q, state_d;
    logic [3:0]    bitcnt_q;
    logic [BW-1:0] shreg_q;
    logic [BW-1:0] rd_shift_q;
    logic [BW-1:0] ptr_q;
    logic          rw_q;
    logic          wr_done_q;
    logic          sda_oe_q;
    logic          wr_stb_q;
    logic          wr_stop_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [BW-1:0] wr_data_q;

    logic [BW-1:0] rf_rdata;
    logic [BW-1:0] rd_value;
    logic          ptr_in_range;
    logic          byte_done;
    logic          shift_state;
    logic          dev_match;

    assign ptr_in_range = (ptr_q < BW'(NUM_REGS));
    assign rd_value     = ptr_in_range ? rf_rdata : '0;
    assign byte_done    = ev_fall && (bitcnt_q == BITS_FULL);
    assign dev_match    = (shreg_q[BW-1:1] == DEV_ADDR);
    assign shift_state  = (state_q == ST_DEVADDR) || (state_q == ST_REGADDR) ||
                          (state_q == ST_WDATA)   || (state_q == ST_RDATA);

    twr_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(BW)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_stb_q),
        .waddr (wr_addr_q),
        .wdata (wr_data_q),
        .raddr (ptr_q[ADDR_W-1:0]),
        .rdata (rf_rdata),
        .bank  (reg_bank)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (ev_stop) begin
            state_d = ST_IDLE;
        end else if (ev_start) begin
            state_d = ST_DEVADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEVADDR: if (byte_done) state_d = dev_match ? ST_DEVACK : ST_IGNORE;
                ST_DEVACK:  if (ev_fall)   state_d = rw_q ? ST_RDATA : ST_REGADDR;
                ST_REGADDR: if (byte_done) state_d = ST_REGACK;
                ST_REGACK:  if (ev_fall)   state_d = ST_WDATA;
                ST_WDATA:   if (byte_done) state_d = ST_WDACK;
                ST_WDACK:   if (ev_fall)   state_d = ST_DONE;
                ST_RDATA:   if (byte_done) state_d = ST_RDACK;
                ST_RDACK:   if (ev_fall)   state_d = ST_DONE;
                ST_DONE:    state_d = ST_DONE;
                ST_IGNORE:  state_d = ST_IGNORE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and datapath: SDA only changes on a clock-low event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q   <= '0;
            shreg_q    <= '0;
            rd_shift_q <= '0;
            ptr_q      <= '0;
            rw_q       <= 1'b0;
            wr_done_q  <= 1'b0;
            sda_oe_q   <= 1'b0;
            wr_stb_q   <= 1'b0;
            wr_stop_q  <= 1'b0;
            wr_addr_q  <= '0;
            wr_data_q  <= '0;
        end else begin
            wr_stb_q  <= 1'b0;
            wr_stop_q <= 1'b0;
            if (ev_stop) begin
                sda_oe_q  <= 1'b0;
                wr_stop_q <= wr_done_q;
                wr_done_q <= 1'b0;
                bitcnt_q  <= '0;
            end else if (ev_start) begin
                sda_oe_q  <= 1'b0;
                wr_done_q <= 1'b0;
                bitcnt_q  <= '0;
            end else begin
                if (ev_rise && shift_state) begin
                    shreg_q  <= {shreg_q[BW-2:0], sda_s};
                    bitcnt_q <= bitcnt_q + 4'd1;
                end
                if (ev_fall) begin
                    unique case (state_q)
                        ST_DEVADDR: begin
                            if (bitcnt_q == BITS_FULL) begin
                                sda_oe_q <= dev_match;
                                rw_q     <= shreg_q[0];
                            end
                        end
                        ST_DEVACK: begin
                            bitcnt_q   <= '0;
                            rd_shift_q <= rd_value;
                            sda_oe_q   <= rw_q ? ~rd_value[BW-1] : 1'b0;
                        end
                        ST_REGADDR: begin
                            if (bitcnt_q == BITS_FULL) begin
                                ptr_q    <= shreg_q;
                                sda_oe_q <= 1'b1;
                            end
                        end
                        ST_REGACK: begin
                            bitcnt_q <= '0;
                            sda_oe_q <= 1'b0;
                        end
                        ST_WDATA: begin
                            if (bitcnt_q == BITS_FULL) begin
                                sda_oe_q <= 1'b1;
                                if (ptr_in_range) begin
                                    wr_stb_q  <= 1'b1;
                                    wr_done_q <= 1'b1;
                                    wr_addr_q <= ptr_q[ADDR_W-1:0];
                                    wr_data_q <= shreg_q;
                                end
                            end
                        end
                        ST_WDACK: sda_oe_q <= 1'b0;
                        ST_RDATA: begin
                            if (bitcnt_q == BITS_FULL) begin
                                sda_oe_q <= 1'b0;
                            end else if (bitcnt_q != 4'd0) begin
                                rd_shift_q <= {rd_shift_q[BW-2:0], 1'b0};
                                sda_oe_q   <= ~rd_shift_q[BW-2];
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_oe  = sda_oe_q;
    assign wr_stb  = wr_stb_q;
    assign wr_addr = wr_addr_q;
    assign wr_data = wr_data_q;
    assign wr_stop = wr_stop_q;

endmodule

// File: rtl/twr_checker.sv
module twr_checker #(
    parameter int NUM_REGS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_s,
    input logic                  sda_oe,
    input logic                  wr_stb,
    input logic                  wr_stop,
    input twr_pkg::twr_state_e   state_q,
    input logic [NUM_REGS*8-1:0] reg_bank
);
    import twr_pkg::*;

    // R6: drive changes only follow a clock-low sample
    assert_drive_while_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

    // R4: write strobe lasts one cycle
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R8: stop pulse lasts one cycle
    assert_stop_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> !wr_stop);

    // R3: no drive while ignoring a foreign address
    assert_ignore_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |-> !sda_oe);

    // R2: idle means the line is released
    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe);

    // R10: bank changes only after a strobe
    assert_bank_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(reg_bank));

endmodule

bind twowire_regbank_slave twr_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (scl_s),
    .sda_oe   (sda_oe),
    .wr_stb   (wr_stb),
    .wr_stop  (wr_stop),
    .state_q  (state_q),
    .reg_bank (reg_bank)
);

// File: tb/twowire_regbank_slave_tb.sv
module twowire_regbank_slave_tb;

    localparam int NREG = 16;
    localparam int Q    = 5;
    localparam logic [6:0] DEV = 7'b0001000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, wr_stb, wr_stop;
    logic [3:0] wr_addr;
    logic [7:0] wr_data;
    logic [NREG*8-1:0] reg_bank;
    wire sda_line = sda_m & ~sda_oe;

    twowire_regbank_slave u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_stop  (wr_stop),
        .reg_bank (reg_bank)
    );

    int n_chk = 0;
    int n_fail = 0;
    int stb_cnt = 0;
    int stop_cnt = 0;
    int drive_cnt = 0;
    int edge_bad = 0;
    logic [3:0] stb_addr = '0;
    logic [7:0] stb_data = '0;
    logic prev_oe = 1'b0;
    logic prev_scl = 1'b1;
    logic [7:0] model [NREG];

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_cnt++;
                stb_addr = wr_addr;
                stb_data = wr_data;
            end
            if (wr_stop) stop_cnt++;
            if (sda_oe) drive_cnt++;
            if ((sda_oe !== prev_oe) && scl_m && prev_scl) edge_bad++;
        end
        prev_oe  = sda_oe;
        prev_scl = scl_m;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b0; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic bus_stop;
        scl_m = 1'b0; sda_m = 1'b0; hold(Q);
        scl_m = 1'b1; hold(Q);
        sda_m = 1'b1; hold(Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i >= 8 - n; i--) begin
            sda_m = b[i]; hold(Q);
            scl_m = 1'b1; hold(Q);
            scl_m = 1'b0; hold(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        sda_m = 1'b1; hold(Q);
        scl_m = 1'b1; hold(2);
        acked = ~sda_line;
        hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic read_byte(input logic master_nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; hold(Q);
            scl_m = 1'b1; hold(2);
            b[i] = sda_line;
            hold(Q);
            scl_m = 1'b0; hold(Q);
        end
        sda_m = master_nack; hold(Q);
        scl_m = 1'b1; hold(Q);
        scl_m = 1'b0; hold(Q);
    endtask

    task automatic write_txn(input logic [7:0] r, input logic [7:0] d, output logic [2:0] acks);
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(r, acks[1]);
        send_byte(d, acks[0]);
        bus_stop;
    endtask

    task automatic read_txn(input logic [7:0] r, output logic [7:0] d, output logic [2:0] acks);
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(r, acks[1]);
        bus_start;
        send_byte({DEV, 1'b1}, acks[0]);
        read_byte(1'b1, d);
        bus_stop;
    endtask

    initial begin
        logic [2:0] acks;
        logic [7:0] rd;
        logic       a;
        int         s0, t0, d0;
        logic [NREG*8-1:0] snap;

        for (int i = 0; i < NREG; i++) model[i] = 8'h00;
        rst_n = 1'b0;
        hold(5);
        rst_n = 1'b1;
        hold(5);

        // R1: reset state at the ports
        check(sda_oe == 1'b0, "R1 sda_oe after reset", int'(sda_oe), 0);
        check(!wr_stb && !wr_stop, "R1 strobes after reset", int'({wr_stb, wr_stop}), 0);
        check(reg_bank == '0, "R1 bank after reset", int'(reg_bank[31:0]), 0);
        for (int i = 0; i < NREG; i++) begin
            read_txn(8'(i), rd, acks);
            check(acks == 3'b111, "R1 read acks after reset", int'(acks), 7);
            check(rd == 8'h00, "R1 register zero after reset", int'(rd), 0);
        end

        // R4 R8 R10: write every register
        for (int i = 0; i < NREG; i++) begin
            s0 = stb_cnt; t0 = stop_cnt;
            write_txn(8'(i), pat(i), acks);
            model[i] = pat(i);
            check(acks == 3'b111, "R4 write acks", int'(acks), 7);
            check(stb_cnt == s0 + 1, "R4 one strobe per write", stb_cnt - s0, 1);
            check(stb_addr == 4'(i) && stb_data == pat(i), "R4 strobe addr/data",
                  int'({stb_addr, stb_data}), int'({4'(i), pat(i)}));
            check(stop_cnt == t0 + 1, "R8 stop pulse after write", stop_cnt - t0, 1);
            check(reg_bank[i*8 +: 8] == pat(i), "R4 register updated", int'(reg_bank[i*8 +: 8]), int'(pat(i)));
        end
        for (int i = 0; i < NREG; i++)
            check(reg_bank[i*8 +: 8] == model[i], "R10 bank layout", int'(reg_bank[i*8 +: 8]), int'(model[i]));

        // R6 R8: read every register back
        t0 = stop_cnt; s0 = stb_cnt;
        for (int i = 0; i < NREG; i++) begin
            read_txn(8'(i), rd, acks);
            check(acks == 3'b111, "R6 read acks", int'(acks), 7);
            check(rd == model[i], "R6 read data MSB first", int'(rd), int'(model[i]));
        end
        check(stop_cnt == t0, "R8 no stop pulse after reads", stop_cnt - t0, 0);
        check(stb_cnt == s0, "R8 no strobe on reads", stb_cnt - s0, 0);
        check(edge_bad == 0, "R6 slave drive changed with clock high", edge_bad, 0);

        // R7: out-of-range register addresses
        foreach (acks[k]) ;
        for (int k = 0; k < 4; k++) begin
            logic [7:0] ra;
            ra = (k == 0) ? 8'h10 : (k == 1) ? 8'h2A : (k == 2) ? 8'h80 : 8'hFF;
            s0 = stb_cnt; t0 = stop_cnt; snap = reg_bank;
            write_txn(ra, 8'h5A, acks);
            check(acks == 3'b111, "R7 out-of-range write acked", int'(acks), 7);
            check(stb_cnt == s0 && stop_cnt == t0, "R7 out-of-range write no strobe",
                  stb_cnt - s0 + stop_cnt - t0, 0);
            check(reg_bank == snap, "R7 bank unchanged", int'(reg_bank[31:0]), int'(snap[31:0]));
            read_txn(ra, rd, acks);
            check(rd == 8'h00, "R7 out-of-range read zero", int'(rd), 0);
        end

        // R5: extra data byte is refused
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'h03, acks[1]);
        send_byte(8'hC3, acks[0]);
        check(acks == 3'b111, "R5 first data byte acked", int'(acks), 7);
        send_byte(8'h3C, a);
        check(a == 1'b0, "R5 extra byte not acked", int'(a), 0);
        bus_stop;
        model[3] = 8'hC3;
        check(stb_cnt == s0 + 1, "R5 only one strobe", stb_cnt - s0, 1);
        check(reg_bank[3*8 +: 8] == 8'hC3, "R5 extra byte not written", int'(reg_bank[3*8 +: 8]), 'hC3);

        // R3: sweep every device address and direction
        s0 = stb_cnt; snap = reg_bank;
        for (int ad = 0; ad < 128; ad++) begin
            for (int dir = 0; dir < 2; dir++) begin
                if (7'(ad) != DEV) begin
                    d0 = drive_cnt;
                    bus_start;
                    send_byte({7'(ad), 1'(dir)}, a);
                    check(a == 1'b0, "R3 foreign address not acked", ad, 0);
                    send_byte(8'h00, a);
                    bus_stop;
                    check(drive_cnt == d0, "R3 no drive after mismatch", drive_cnt - d0, 0);
                end
            end
        end
        check(stb_cnt == s0, "R3 no strobe on mismatch", stb_cnt - s0, 0);
        check(reg_bank == snap, "R3 bank unchanged", int'(reg_bank[31:0]), int'(snap[31:0]));

        // R9: repeated start mid register-address byte
        s0 = stb_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_bits(8'hF0, 4);
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'h05, acks[1]);
        send_byte(8'h77, acks[0]);
        bus_stop;
        model[5] = 8'h77;
        check(acks == 3'b111, "R9 restart mid-byte acks", int'(acks), 7);
        check(stb_cnt == s0 + 1 && stb_addr == 4'd5, "R9 restart mid-byte write", int'(stb_addr), 5);
        check(reg_bank[5*8 +: 8] == 8'h77, "R9 register after restart", int'(reg_bank[5*8 +: 8]), 'h77);

        // R9: repeated start while ignoring a foreign address
        bus_start;
        send_byte({7'h09, 1'b0}, a);
        check(a == 1'b0, "R9 foreign address before restart", int'(a), 0);
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'h06, acks[1]);
        send_byte(8'hA6, acks[0]);
        bus_stop;
        model[6] = 8'hA6;
        check(acks == 3'b111 && reg_bank[6*8 +: 8] == 8'hA6, "R9 restart after ignore",
              int'(reg_bank[6*8 +: 8]), 'hA6);

        // R2 R8: pointer-only transaction, then a read after stop/start
        s0 = stb_cnt; t0 = stop_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, acks[2]);
        send_byte(8'h09, acks[1]);
        bus_stop;
        check(stb_cnt == s0 && stop_cnt == t0, "R8 pointer-only no pulses", stop_cnt - t0, 0);
        check(sda_oe == 1'b0, "R2 released after stop", int'(sda_oe), 0);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        read_byte(1'b1, rd);
        bus_stop;
        check(a == 1'b1 && rd == model[9], "R2 read after stop uses pointer", int'(rd), int'(model[9]));

        for (int i = 0; i < NREG; i++)
            check(reg_bank[i*8 +: 8] == model[i], "R10 final bank", int'(reg_bank[i*8 +: 8]), int'(model[i]));
        check(edge_bad == 0, "R6 final drive-edge count", edge_bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule